// File: doc/BRIEF.md
# Half-Supply Detect Qualification Filter

This block decides when a half-supply level detection counts as real. An analog comparator elsewhere reports, through a synchronous input, that a monitored line sits at half the supply voltage. The block keeps a small host-written control byte. One bit of that byte is an enable, and two bits pick how long the detection must hold without a break. The block counts millisecond ticks while the detection stays high. When the count reaches the chosen delay and the enable is set, a sticky status bit is raised.

The status bit stays set until the host pulses a clear input. When the enable is off, detection can never raise the status bit, although the timer still runs. Any write to the control byte restarts the timer, so a new delay setting always starts from zero. The time base comes from an external one-cycle tick, one per millisecond.

Top module: `hld_qual_filter`

## Requirements
- R1: After reset the control readback is 0x00, which means disabled with the shortest delay selected, and the status output is 0.
- R2: A write stores data bits 2..0: bit 2 is the enable and bits 1..0 are the delay select. Data bits 7..3 are ignored, and readback always shows them as 0.
- R3: With the enable at 1, select code 00 needs 100 ticks, 01 needs 250, 10 needs 500 and 11 needs 1000 ticks while detection is continuously high. The status output rises on the clock edge after the tick that completes the count. One tick fewer leaves the status at 0.
- R4: Any cycle with the detect input low sets the elapsed count back to zero, so only an unbroken assertion qualifies.
- R5: The elapsed count advances only in cycles where the tick input is high. Clock cycles without a tick do not move it.
- R6: While the enable bit is 0, the status output never goes from 0 to 1, however long detection is held.
- R7: Once set, the status output stays 1 until the clear input is high at a clock edge, which forces it to 0. Clear wins over a set in the same cycle.
- R8: A control write sets the elapsed count back to zero, even if the written value is unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Control write strobe, one cycle per write |
| wr_data | input | 8 | Control byte to write |
| ctrl_rd | output | 8 | Control byte readback, with bits 7..3 always 0 |
| ms_tick | input | 1 | One-cycle pulse per millisecond |
| det_in | input | 1 | Synchronous half-supply detect indication |
| clr | input | 1 | Clears the status bit |
| status_o | output | 1 | Sticky qualified-detection status |

## Verification
For every select code, detection is held for exactly one tick less than the delay and then for the full delay. This shows that each code maps to its own count and confirms where the count boundary falls. A run broken by one low cycle halfway through, and a long stretch of clock cycles with no ticks, show the difference between a count that resets on a low input and one that only pauses, and between counting ticks and counting clocks. Long holds with the enable off, a rewrite partway through a count, and a clear applied after detection has dropped separate the enable gating, the restart on write and the sticky behaviour.

// File: rtl/hld_pkg.sv
package hld_pkg;

    // Number of bits of the control byte that carry meaning.
    localparam int CTRL_USED_W = 3;

    typedef struct packed {
        logic       en;
        logic [1:0] sel;
    } hld_ctrl_t;

endpackage

// File: rtl/hld_ctrl_reg.sv
module hld_ctrl_reg
    import hld_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [BYTE_W-1:0] wr_data,
    output hld_ctrl_t         ctrl,
    output logic [BYTE_W-1:0] rd_byte
);

    localparam int PAD_W = BYTE_W - CTRL_USED_W;

    typedef struct packed {
        hld_ctrl_t ctrl;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.ctrl.en  = wr_data[2];
            st_d.ctrl.sel = wr_data[1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ctrl    = st_q.ctrl;
    assign rd_byte = {{PAD_W{1'b0}}, st_q.ctrl};

endmodule

// File: rtl/hld_delay_sel.sv
module hld_delay_sel #(
    parameter int DLY0  = 100,
    parameter int DLY1  = 250,
    parameter int DLY2  = 500,
    parameter int DLY3  = 1000,
    parameter int CNT_W = 10
) (
    input  logic [1:0]       sel,
    output logic [CNT_W-1:0] target
);

    localparam int NSEL = 4;
    localparam int DLY_TBL [NSEL] = '{DLY0, DLY1, DLY2, DLY3};

    logic [CNT_W-1:0] opt [NSEL];

    for (genvar g = 0; g < NSEL; g++) begin : g_opt
        assign opt[g] = CNT_W'(DLY_TBL[g]);
    end

    always_comb begin
        target = opt[sel];
    end

endmodule

// File: rtl/hld_qual_timer.sv
module hld_qual_timer #(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             det_in,
    input  logic             ms_tick,
    input  logic             en,
    input  logic [CNT_W-1:0] target,
    input  logic             clr,
    output logic [CNT_W-1:0] cnt,
    output logic             status
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             status;
    } state_t;

    state_t st_d, st_q;
    logic   reached;

    always_comb begin
        st_d    = st_q;
        reached = (st_q.cnt == target);

        // Elapsed count of unbroken detection
        if (restart || !det_in) begin
            st_d.cnt = '0;
        end else if (ms_tick && (st_q.cnt < target)) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end

        // Sticky status; the clear has priority
        if (clr) begin
            st_d.status = 1'b0;
        end else if (en && det_in && reached) begin
            st_d.status = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt    = st_q.cnt;
    assign status = st_q.status;

endmodule

// File: rtl/hld_qual_filter.sv
module hld_qual_filter
    import hld_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int DLY0   = 100,
    parameter int DLY1   = 250,
    parameter int DLY2   = 500,
    parameter int DLY3   = 1000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [BYTE_W-1:0] wr_data,
    output logic [BYTE_W-1:0] ctrl_rd,
    input  logic              ms_tick,
    input  logic              det_in,
    input  logic              clr,
    output logic              status_o
);

    localparam int MAX01  = (DLY0 > DLY1) ? DLY0 : DLY1;
    localparam int MAX23  = (DLY2 > DLY3) ? DLY2 : DLY3;
    localparam int DLYMAX = (MAX01 > MAX23) ? MAX01 : MAX23;
    localparam int CNT_W  = $clog2(DLYMAX + 1);

    hld_ctrl_t        ctrl;
    logic [CNT_W-1:0] target;
    logic [CNT_W-1:0] cnt_q;

    hld_ctrl_reg #(.BYTE_W(BYTE_W)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .ctrl    (ctrl),
        .rd_byte (ctrl_rd)
    );

    hld_delay_sel #(
        .DLY0  (DLY0),
        .DLY1  (DLY1),
        .DLY2  (DLY2),
        .DLY3  (DLY3),
        .CNT_W (CNT_W)
    ) u_sel (
        .sel    (ctrl.sel),
        .target (target)
    );

    hld_qual_timer #(.CNT_W(CNT_W)) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (wr_en),
        .det_in  (det_in),
        .ms_tick (ms_tick),
        .en      (ctrl.en),
        .target  (target),
        .clr     (clr),
        .cnt     (cnt_q),
        .status  (status_o)
    );

endmodule

// File: rtl/hld_qual_filter_chk.sv
module hld_qual_filter_chk #(
    parameter int BYTE_W = 8,
    parameter int CNT_W  = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic              ms_tick,
    input logic              det_in,
    input logic              clr,
    input logic [BYTE_W-1:0] ctrl_rd,
    input logic              status_o,
    input logic [CNT_W-1:0]  cnt,
    input logic [CNT_W-1:0]  target
);

    p_upper_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_rd[BYTE_W-1:3] == '0);

    p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= target);

    p_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_rd[2] && det_in && (cnt == target) && !clr) |=> status_o);

    p_det_low_reset_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !det_in |=> (cnt == '0));

    p_no_tick_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (det_in && !ms_tick && !wr_en) |=> $stable(cnt));

    p_disabled_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_rd[2] && !status_o) |=> !status_o);

    p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !status_o);

    p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o && !clr) |=> status_o);

    p_write_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (cnt == '0));

endmodule

bind hld_qual_filter hld_qual_filter_chk #(
    .BYTE_W (BYTE_W),
    .CNT_W  (CNT_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .ms_tick  (ms_tick),
    .det_in   (det_in),
    .clr      (clr),
    .ctrl_rd  (ctrl_rd),
    .status_o (status_o),
    .cnt      (cnt_q),
    .target   (target)
);

// File: tb/tb_hld_qual_filter.sv
module tb_hld_qual_filter;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] ctrl_rd;
    logic       ms_tick = 1'b0;
    logic       det_in = 1'b0;
    logic       clr = 1'b0;
    logic       status_o;

    int    n_chk = 0;
    int    n_err = 0;
    bit    done = 1'b0;
    string cur_req = "R1";

    // Reference model state
    int m_ctrl = 0;
    int m_cnt = 0;
    bit m_stat = 1'b0;

    always #10 clk = ~clk;  // 50 MHz

    hld_qual_filter dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .ctrl_rd  (ctrl_rd),
        .ms_tick  (ms_tick),
        .det_in   (det_in),
        .clr      (clr),
        .status_o (status_o)
    );

    function automatic int delay_of(int code);
        case (code)
            0: return 100;
            1: return 250;
            2: return 500;
            default: return 1000;
        endcase
    endfunction

    // Behavioural model evaluated at each active edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_ctrl = 0;
            m_cnt  = 0;
            m_stat = 1'b0;
        end else begin
            int lim;
            bit set_now;
            lim = delay_of(m_ctrl % 4);
            set_now = (m_ctrl / 4 == 1) && det_in && (m_cnt == lim);
            if (clr) m_stat = 1'b0;
            else if (set_now) m_stat = 1'b1;
            if (wr_en || !det_in) m_cnt = 0;
            else if (ms_tick && m_cnt < lim) m_cnt = m_cnt + 1;
            if (wr_en) m_ctrl = int'(wr_data & 8'h07);
        end
    end

    task automatic chk(string req, int got, int exp);
        n_chk++;
        if (got != exp) begin
            n_err++;
            $display("FAIL %s: got %0d expected %0d at %0t", req, got, exp, $time);
        end
    endtask

    // Per-cycle comparison against the model, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk({cur_req, " status"}, int'(status_o), int'(m_stat));
            chk({cur_req, " ctrl"}, int'(ctrl_rd), m_ctrl);
        end
    end

    task automatic step(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic ticks(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); ms_tick = 1'b1;
            @(negedge clk); ms_tick = 1'b0;
        end
    endtask

    task automatic wr(logic [7:0] v);
        @(negedge clk); wr_en = 1'b1; wr_data = v;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic pulse_clr();
        @(negedge clk); clr = 1'b1;
        @(negedge clk); clr = 1'b0;
    endtask

    initial begin
        #(200000 * 20);
        n_err++;
        n_chk++;
        $display("FAIL watchdog: got timeout expected completion");
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        step(3);
        rst_n = 1'b1;
        step(1);
        // R1: reset state
        chk("R1 reset ctrl", int'(ctrl_rd), 0);
        chk("R1 reset status", int'(status_o), 0);

        // R2: upper bits ignored on write
        cur_req = "R2";
        wr(8'hFD);
        chk("R2 readback", int'(ctrl_rd), 5);
        wr(8'hF8);
        chk("R2 readback zero", int'(ctrl_rd), 0);

        // R3: each delay code, boundary one tick before and at the count
        cur_req = "R3";
        for (int c = 0; c < 4; c++) begin
            wr(8'(4 + c));
            pulse_clr();
            @(negedge clk); det_in = 1'b1;
            ticks(delay_of(c) - 1);
            step(2);
            chk($sformatf("R3 code %0d one short", c), int'(status_o), 0);
            ticks(1);
            step(1);
            chk($sformatf("R3 code %0d reached", c), int'(status_o), 1);
            @(negedge clk); det_in = 1'b0;
            step(1);
        end

        // R7: sticky after detection drops, then clear
        cur_req = "R7";
        step(20);
        chk("R7 sticky", int'(status_o), 1);
        pulse_clr();
        chk("R7 cleared", int'(status_o), 0);
        step(10);
        chk("R7 stays clear", int'(status_o), 0);

        // R4: a single low cycle breaks the run
        cur_req = "R4";
        wr(8'h04);
        @(negedge clk); det_in = 1'b1;
        ticks(60);
        @(negedge clk); det_in = 1'b0;
        @(negedge clk); det_in = 1'b1;
        ticks(60);
        step(2);
        chk("R4 broken run not qualified", int'(status_o), 0);
        ticks(40);
        step(1);
        chk("R4 fresh run qualified", int'(status_o), 1);
        @(negedge clk); det_in = 1'b0;
        pulse_clr();

        // R5: clock cycles without ticks do not count
        cur_req = "R5";
        @(negedge clk); det_in = 1'b1;
        ticks(99);
        step(500);
        chk("R5 no tick no count", int'(status_o), 0);
        ticks(1);
        step(1);
        chk("R5 hundredth tick", int'(status_o), 1);
        @(negedge clk); det_in = 1'b0;
        pulse_clr();

        // R6: disabled never sets
        cur_req = "R6";
        wr(8'h00);
        @(negedge clk); det_in = 1'b1;
        ticks(300);
        step(2);
        chk("R6 disabled no status", int'(status_o), 0);
        // enabling restarts the count (R8)
        wr(8'h04);
        ticks(99);
        step(1);
        chk("R8 enable write restarts", int'(status_o), 0);
        ticks(1);
        step(1);
        chk("R6 enabled sets", int'(status_o), 1);

        // R7: clear wins while the set condition holds
        cur_req = "R7";
        pulse_clr();
        chk("R7 clear priority", int'(status_o), 0);
        step(1);
        chk("R7 resets while qualified", int'(status_o), 1);
        @(negedge clk); det_in = 1'b0;
        pulse_clr();

        // R8: rewriting the same value restarts
        cur_req = "R8";
        wr(8'h05);
        @(negedge clk); det_in = 1'b1;
        ticks(200);
        wr(8'h05);
        ticks(200);
        step(2);
        chk("R8 rewrite restarts", int'(status_o), 0);
        ticks(50);
        step(1);
        chk("R8 full delay after rewrite", int'(status_o), 1);
        @(negedge clk); det_in = 1'b0;
        step(2);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule